// File: doc/BRIEF.md
# Repeated String Scan and Compare Engine

This block walks through memory one element at a time and compares as it goes. In scan mode each element at the destination pointer is checked against an accumulator value. In compare mode the element at the source pointer is checked against the element at the destination pointer. Elements are one, two or four bytes wide. After every comparison the active pointers move by the element size, up or down as the direction input selects, and a count register drops by one.

A repeat-kind input sets the early exit. In repeat-while-equal the loop ends at the first mismatch. In repeat-while-not-equal it ends at the first match. In both kinds the loop also ends when the count reaches zero. Once the engine stops, it reports the final pointers, the remaining count and a zero flag that holds the result of the last comparison. A one-cycle done pulse marks the end of the operation.

The memory port is a plain synchronous read port. The engine raises a read enable with a byte address, and the data comes back on the next cycle. The data is little-endian, so the byte at the address sits in bits [7:0].

Top module: `strscan_engine`

## Requirements
- R1: In scan mode (cmp_mode=0) each iteration does exactly one memory read, at the destination pointer. The read data is compared with acc_in. The destination pointer advances and the source pointer stays as loaded.
- R2: In compare mode (cmp_mode=1) each iteration reads the source pointer first and then the destination pointer, two reads in all. The two elements are compared, and both pointers advance.
- R3: elem_size encodes 0=byte, 1=word, 2=doubleword (3 acts as doubleword). Only the low 1, 2 or 4 bytes of each operand take part in the equality test. Memory data is little-endian: the byte at the address is in bits [7:0].
- R4: The pointer step is 1, 2 or 4 according to elem_size. It is subtracted when dir_down=1 and added when dir_down=0. The step is applied after every comparison, including the one that ends the loop.
- R5: Each iteration decrements the count by one. The operation stops when the count reaches zero.
- R6: With while_ne=1 the loop also stops after the first equal comparison. With while_ne=0 it also stops after the first unequal comparison.
- R7: zf is 1 when the last comparison was equal and 0 when it was not. zf holds its value between operations and is 0 after reset.
- R8: A start with cnt_in=0 performs no memory read and no comparison. It leaves zf unchanged and returns the loaded pointers and the zero count.
- R9: done is a single-cycle pulse. busy is high from the cycle after start until the done cycle. A start while busy is ignored. After reset, busy and done are 0.
- R10: mem_rdata is sampled in the cycle after the one in which mem_rd_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with the values on the inputs below |
| cmp_mode | input | 1 | 0 = scan against accumulator, 1 = compare source with destination |
| while_ne | input | 1 | 0 = repeat while equal, 1 = repeat while not equal |
| elem_size | input | 2 | Element size code |
| dir_down | input | 1 | 1 = pointers decrement, 0 = increment |
| acc_in | input | 32 | Accumulator value for scan mode |
| src_in | input | AW | Initial source pointer |
| dst_in | input | AW | Initial destination pointer |
| cnt_in | input | CW | Initial repeat count |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | AW | Byte address of the read |
| mem_rdata | input | 32 | Read data, valid one cycle after the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| src_out | output | AW | Current or final source pointer |
| dst_out | output | AW | Current or final destination pointer |
| cnt_out | output | CW | Current or final count |
| zf | output | 1 | Result of the last comparison (1 = equal) |

## Verification
A 100-byte scan for a zero value is run twice: once with a zero planted in the middle and once with none. The two runs separate an early stop on a match from exhaustion of the count. A word-sized compare running downward, with a mismatch on the third element, separates the repeat-while-equal exit and the two-read ordering from the scan path. Size-masking faults show up there because only the selected lanes may decide equality. A zero-count start issued after a matching run shows whether zf and the memory port stay untouched. Seeded random operations mix every mode, size, direction and count over memory built from a small value alphabet, so that matches and mismatches both occur often.

// File: rtl/strscan_pkg.sv
package strscan_pkg;

    localparam int unsigned MAX_BYTES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_S,
        ST_FETCH_D,
        ST_EVAL,
        ST_FIN
    } state_t;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } esize_t;

    typedef struct packed {
        logic   cmp_mode;
        logic   while_ne;
        esize_t size;
        logic   dir_down;
    } op_cfg_t;

    function automatic logic [2:0] step_bytes(esize_t s);
        case (s)
            SZ_BYTE: step_bytes = 3'd1;
            SZ_WORD: step_bytes = 3'd2;
            default: step_bytes = 3'd4;
        endcase
    endfunction

    function automatic logic [MAX_BYTES-1:0] lane_mask(esize_t s);
        case (s)
            SZ_BYTE: lane_mask = 4'b0001;
            SZ_WORD: lane_mask = 4'b0011;
            default: lane_mask = 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/strscan_lane_cmp.sv
module strscan_lane_cmp #(
    parameter int unsigned LANES = 4
) (
    input  logic [8*LANES-1:0] op_a,
    input  logic [8*LANES-1:0] op_b,
    input  logic [LANES-1:0]   lane_en,
    output logic               equal
);
    logic [LANES-1:0] lane_ok;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_ok[g] = !lane_en[g] || (op_a[8*g +: 8] == op_b[8*g +: 8]);
        end
    endgenerate

    assign equal = &lane_ok;
endmodule

// File: rtl/strscan_ptr_step.sv
module strscan_ptr_step
    import strscan_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] ptr,
    input  esize_t        size,
    input  logic          dir_down,
    output logic [AW-1:0] ptr_nx
);
    logic [AW-1:0] delta;

    assign delta  = {{(AW-3){1'b0}}, step_bytes(size)};
    assign ptr_nx = dir_down ? (ptr - delta) : (ptr + delta);
endmodule

// File: rtl/strscan_engine.sv
module strscan_engine
    import strscan_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cmp_mode,
    input  logic          while_ne,
    input  logic [1:0]    elem_size,
    input  logic          dir_down,
    input  logic [31:0]   acc_in,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [31:0]   mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] src_out,
    output logic [AW-1:0] dst_out,
    output logic [CW-1:0] cnt_out,
    output logic          zf
);
    localparam int unsigned DW = 8 * MAX_BYTES;

    state_t        state_q;
    op_cfg_t       cfg_q;
    logic [DW-1:0] acc_q;
    logic [DW-1:0] srcdat_q;
    logic [AW-1:0] src_q, dst_q, src_nx, dst_nx;
    logic [CW-1:0] cnt_q, cnt_nx;
    logic          zf_q;
    logic          eq;
    logic          stop;
    logic [DW-1:0] cmp_a;

    assign cmp_a  = cfg_q.cmp_mode ? srcdat_q : acc_q;
    assign cnt_nx = cnt_q - {{(CW-1){1'b0}}, 1'b1};
    assign stop   = (cnt_nx == '0) || (cfg_q.while_ne ? eq : !eq);

    strscan_lane_cmp #(.LANES(MAX_BYTES)) u_cmp (
        .op_a    (cmp_a),
        .op_b    (mem_rdata),
        .lane_en (lane_mask(cfg_q.size)),
        .equal   (eq)
    );

    strscan_ptr_step #(.AW(AW)) u_src_step (
        .ptr      (src_q),
        .size     (cfg_q.size),
        .dir_down (cfg_q.dir_down),
        .ptr_nx   (src_nx)
    );

    strscan_ptr_step #(.AW(AW)) u_dst_step (
        .ptr      (dst_q),
        .size     (cfg_q.size),
        .dir_down (cfg_q.dir_down),
        .ptr_nx   (dst_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cfg_q    <= '0;
            acc_q    <= '0;
            srcdat_q <= '0;
            src_q    <= '0;
            dst_q    <= '0;
            cnt_q    <= '0;
            zf_q     <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q <= '{cmp_mode: cmp_mode, while_ne: while_ne,
                                   size: esize_t'(elem_size), dir_down: dir_down};
                        acc_q <= acc_in;
                        src_q <= src_in;
                        dst_q <= dst_in;
                        cnt_q <= cnt_in;
                        if (cnt_in == '0)
                            state_q <= ST_FIN;
                        else if (cmp_mode)
                            state_q <= ST_FETCH_S;
                        else
                            state_q <= ST_FETCH_D;
                    end
                end
                ST_FETCH_S: state_q <= ST_FETCH_D;
                ST_FETCH_D: begin
                    if (cfg_q.cmp_mode)
                        srcdat_q <= mem_rdata;
                    state_q <= ST_EVAL;
                end
                ST_EVAL: begin
                    zf_q  <= eq;
                    dst_q <= dst_nx;
                    if (cfg_q.cmp_mode)
                        src_q <= src_nx;
                    cnt_q <= cnt_nx;
                    if (stop)
                        state_q <= ST_FIN;
                    else if (cfg_q.cmp_mode)
                        state_q <= ST_FETCH_S;
                    else
                        state_q <= ST_FETCH_D;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd_en = (state_q == ST_FETCH_S) || (state_q == ST_FETCH_D);
    assign mem_addr  = (state_q == ST_FETCH_S) ? src_q : dst_q;
    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FIN);
    assign src_out   = src_q;
    assign dst_out   = dst_q;
    assign cnt_out   = cnt_q;
    assign zf        = zf_q;

    AST_SCAN_ONE_READ: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH_D) |=> !mem_rd_en); // R1
    AST_CMP_SRC_FIRST: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && mem_addr == src_q && state_q == ST_FETCH_S) |=> (mem_rd_en && mem_addr == dst_q)); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EVAL) |=> (cnt_q == $past(cnt_q) - {{(CW-1){1'b0}}, 1'b1})); // R5
    AST_STOP_REASON: assert property (@(posedge clk) disable iff (rst)
        (done && cnt_q != '0) |-> (zf_q == cfg_q.while_ne)); // R6
    AST_ZF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_EVAL) |=> $stable(zf_q)); // R7
    AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start && cnt_in == '0) |=> (done && !mem_rd_en)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
endmodule

// File: tb/sim_strscan_engine.sv
`timescale 1ns/1ps
module sim_strscan_engine;
    localparam int unsigned AW = 16;
    localparam int unsigned CW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          cmp_mode;
    logic          while_ne;
    logic [1:0]    elem_size;
    logic          dir_down;
    logic [31:0]   acc_in;
    logic [AW-1:0] src_in, dst_in;
    logic [CW-1:0] cnt_in;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata;
    logic          busy, done;
    logic [AW-1:0] src_out, dst_out;
    logic [CW-1:0] cnt_out;
    logic          zf;

    logic [7:0]    mem [256];
    int            rd_cnt;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            exp_zf = 1'b0;

    always #2.5 clk = ~clk;

    strscan_engine #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .start(start), .cmp_mode(cmp_mode),
        .while_ne(while_ne), .elem_size(elem_size), .dir_down(dir_down),
        .acc_in(acc_in), .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .src_out(src_out), .dst_out(dst_out),
        .cnt_out(cnt_out), .zf(zf)
    );

    function automatic logic [31:0] rd32(logic [15:0] a);
        logic [7:0] b0, b1, b2, b3;
        b0 = a[7:0];
        b1 = b0 + 8'd1;
        b2 = b0 + 8'd2;
        b3 = b0 + 8'd3;
        return {mem[b3], mem[b2], mem[b1], mem[b0]};
    endfunction

    function automatic logic [31:0] size_mask(bit [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [15:0] size_step(bit [1:0] sz);
        case (sz)
            2'd0:    return 16'd1;
            2'd1:    return 16'd2;
            default: return 16'd4;
        endcase
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= rd32(mem_addr);
        if (rst) rd_cnt <= 0;
        else if (mem_rd_en) rd_cnt <= rd_cnt + 1;
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic run_op(bit m, bit ne, bit [1:0] sz, bit dn, logic [31:0] acc,
                          logic [15:0] s, logic [15:0] d, logic [15:0] c,
                          bit poke, string tag);
        logic [15:0] es, ed, ec;
        int          reads, r0, k;
        logic [31:0] a, b;
        bit          eq;
        es = s; ed = d; ec = c; reads = 0;
        while (ec != 0) begin
            if (m) begin a = rd32(es); reads++; end else a = acc;
            b = rd32(ed); reads++;
            eq = ((a ^ b) & size_mask(sz)) == 32'd0;
            exp_zf = eq;
            ed = dn ? ed - size_step(sz) : ed + size_step(sz);
            if (m) es = dn ? es - size_step(sz) : es + size_step(sz);
            ec = ec - 16'd1;
            if (ec == 0 || (ne ? eq : !eq)) break;
        end
        @(negedge clk);
        r0 = rd_cnt;
        cmp_mode = m; while_ne = ne; elem_size = sz; dir_down = dn;
        acc_in = acc; src_in = s; dst_in = d; cnt_in = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            start = 1'b1; cnt_in = 16'd0; cmp_mode = ~m; dst_in = 16'h1234;
            @(negedge clk);
            start = 1'b0;
        end
        k = 0;
        while (!done && k < 2000) begin
            @(negedge clk);
            k++;
        end
        chk({tag, " done seen (R9)"}, {31'd0, done}, 32'd1);
        chk({tag, " dst (R4)"}, {16'd0, dst_out}, {16'd0, ed});
        chk({tag, m ? " src (R2)" : " src held (R1)"}, {16'd0, src_out}, {16'd0, es});
        chk({tag, " count (R5)"}, {16'd0, cnt_out}, {16'd0, ec});
        chk({tag, " zf (R7)"}, {31'd0, zf}, {31'd0, exp_zf});
        chk({tag, " reads (R10)"}, rd_cnt - r0, reads);
        @(negedge clk);
        chk({tag, " done pulse/busy (R9)"}, {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1357));
        rst = 1'b1; start = 1'b0; cmp_mode = 1'b0; while_ne = 1'b0;
        elem_size = 2'd0; dir_down = 1'b0; acc_in = '0;
        src_in = '0; dst_in = '0; cnt_in = '0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i + 1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset busy/done/read (R9)", {29'd0, busy, done, mem_rd_en}, 32'd0);
        chk("reset zf (R7)", {31'd0, zf}, 32'd0);

        // R6 R1: 100-byte scan for zero with a zero at byte 57
        for (int i = 0; i < 256; i++) mem[i] = 8'h5A;
        mem[57] = 8'h00;
        run_op(1'b0, 1'b1, 2'd0, 1'b0, 32'hFFFF_FF00, 16'h0300, 16'h0000, 16'd100, 1'b0, "R6 scan hit");
        // R8: zero count after a matching run keeps zf=1 and reads nothing
        run_op(1'b1, 1'b0, 2'd2, 1'b1, 32'd0, 16'h0010, 16'h0020, 16'd0, 1'b0, "R8 empty");
        // R5: no zero present, count runs out
        mem[57] = 8'h5A;
        run_op(1'b0, 1'b1, 2'd0, 1'b0, 32'h0000_0000, 16'h0000, 16'h0000, 16'd100, 1'b0, "R5 scan exhaust");

        // R2 R3 R4: word compare downward, mismatch on third element
        for (int i = 0; i < 32; i++) begin
            mem[8'h20 + i] = 8'(i + 1);
            mem[8'h60 + i] = 8'(i + 1);
        end
        mem[8'h7B] = 8'hEE;
        run_op(1'b1, 1'b0, 2'd1, 1'b1, 32'd0, 16'h003E, 16'h007E, 16'd10, 1'b0, "R3 word cmp");
        // R3: upper lanes ignored for byte size
        run_op(1'b0, 1'b1, 2'd0, 1'b0, 32'hABCD_EF05, 16'h0000, 16'h0020, 16'd8, 1'b0, "R3 byte mask");
        // R3: doubleword scan upward while equal
        for (int i = 0; i < 64; i++) mem[8'h80 + i] = 8'(8'h11 * (i % 4) + 8'h11);
        mem[8'h8C] = 8'h00;
        run_op(1'b0, 1'b0, 2'd2, 1'b0, 32'h4433_2211, 16'h0000, 16'h0080, 16'd12, 1'b0, "R3 dword scan");
        // R9: start while busy is ignored
        run_op(1'b0, 1'b0, 2'd2, 1'b0, 32'h4433_2211, 16'h0000, 16'h0080, 16'd2, 1'b1, "R9 busy start");

        for (int t = 0; t < 60; t++) begin
            if (t % 6 == 0)
                for (int i = 0; i < 256; i++) mem[i] = 8'($urandom % 3);
            run_op(1'($urandom), 1'($urandom), 2'($urandom % 3), 1'($urandom),
                   {8'($urandom % 3), 8'($urandom % 3), 8'($urandom % 3), 8'($urandom % 3)},
                   16'($urandom), 16'($urandom), 16'($urandom % 24), 1'b0, "R6 random");
        end
        finish_run();
    end
endmodule